// File: doc/BRIEF.md
# Oscillator Stabilization Wait Controller

This block owns the on/off control of a fast and a slow oscillator and keeps each oscillator's clock away from the rest of the chip until that oscillator has had time to settle. Software reaches it through one 8-bit control register on the bus clock. The register holds the two enable bits and a 2-bit code that picks the fast-oscillator wait length. A larger code gives a shorter wait.

Each oscillator has a wait timer clocked by that oscillator itself. The fast timer starts a new wait when reset is released, when a sleep period ends, and when software turns the fast oscillator back on. The slow timer starts a fixed-length wait when software turns the slow oscillator back on. Each timer drives a "clock ok" output in its own clock domain, which downstream gating uses to pass that clock on.

After power-up the block holds the CPU until the first fast wait has finished. A write can never switch off the oscillator that currently feeds the system clock. Events and levels cross from the bus domain into each oscillator domain through two-flop synchronizers. The fast "clock ok" comes back to the bus domain through another synchronizer, where it releases the CPU hold.

Top module: `osc_wait_ctrl`

## Requirements
- R1: The fast wait length, counted in fast-oscillator cycles, is set by register bits [5:4]: code 0 gives 1024, code 1 gives 512, code 2 gives 256 and code 3 gives 128. `fast_clk_ok` rises between that count and that count plus 6 fast cycles after the write that starts the wait.
- R2: After reset the register reads 0x03: wait code 0, and both enables set. The first fast wait lasts 1024 fast cycles, measured from reset release with up to 8 cycles of synchronizer latency.
- R3: `cpu_hold` is 1 from reset until the first fast wait has finished. It then stays 0 until the next reset, including through sleep periods.
- R4: Bit 0 is the fast enable and bit 1 is the slow enable. Bits [7:6] and [3:2] always read 0, whatever value was written to them.
- R5: A fast wait restarts when the fast enable goes from 0 to 1 and when `sleep_req` falls.
- R6: `sysclk_sel` names the oscillator that feeds the system clock (0 = fast, 1 = slow). A write that clears the enable of the selected oscillator leaves that bit at 1, and that oscillator's clock-ok output stays 1.
- R7: A write that is allowed to clear an enable bit drops that oscillator's clock-ok output within 8 of its own cycles and resets its counter.
- R8: When the slow enable goes from 0 to 1, `slow_clk_ok` rises after 256 slow cycles, with up to 6 cycles of synchronizer latency.
- R9: While `sleep_req` is 1, `fast_osc_on` is 0 and `fast_clk_ok` drops to 0.
- R10: The wait length is captured when a wait starts. A new code written during a wait takes effect only at the next wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| fclk | input | 1 | Fast oscillator clock |
| sclk | input | 1 | Slow oscillator clock |
| wr_en | input | 1 | Register write strobe (bus clock) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| sleep_req | input | 1 | Sleep request (bus clock); stops the fast oscillator |
| sysclk_sel | input | 1 | Current system clock source: 0 fast, 1 slow |
| fast_osc_on | output | 1 | Fast oscillator run enable |
| slow_osc_on | output | 1 | Slow oscillator run enable |
| fast_clk_ok | output | 1 | Fast clock may be passed on (fclk domain) |
| slow_clk_ok | output | 1 | Slow clock may be passed on (sclk domain) |
| cpu_hold | output | 1 | Holds the CPU during the power-up wait |

## Verification
On every cycle, the assertions check the following:
- a write can never clear the enable of the oscillator that feeds the system clock;
- `cpu_hold` is released only after the synchronized fast clock-ok is seen, and is never raised again;
- each counter stays below the length captured for the wait in progress;
- a stopped oscillator's clock-ok falls in the cycle after its synchronized run level drops.

Only the bench scenarios can show the following:
- the exact wait length for each select code, for the slow oscillator and from reset;
- which events restart a wait;
- that a code changed mid-wait leaves the current wait unchanged;
- that reserved bits read back as zero.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_WAIT  = 2'd1,
    TMR_READY = 2'd2
  } tmr_state_e;

  localparam int CH_FAST = 0;
  localparam int CH_SLOW = 1;
  localparam int NUM_CH  = 2;

  // system clock source encoding on sysclk_sel
  localparam logic SRC_FAST = 1'b0;
  localparam logic SRC_SLOW = 1'b1;

  // control register field positions
  localparam int FEN_BIT = 0;
  localparam int SEN_BIT = 1;
  localparam int SEL_LSB = 4;

  // code 3 is the shortest wait, every step down doubles it
  function automatic int fast_wait_len(input logic [1:0] code, input int base);
    return base << (3 - int'(code));
  endfunction

endpackage

// File: rtl/osc_sync2.sv
module osc_sync2 #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/osc_rst_sync.sv
module osc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage   <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage   <= 1'b1;
      rst_n_o <= stage;
    end
  end
endmodule

// File: rtl/osc_wait_timer.sv
module osc_wait_timer
  import osc_wait_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tok_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ready_o,
  output tmr_state_e       state_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic [LEN_W-1:0] len_q_o,
  output logic             run_s_o
);
  logic [1:0]       ctl_s;
  logic [LEN_W-1:0] len_s;
  logic             tok_q;
  logic             restart;
  logic             run_s;

  osc_sync2 #(.W(2)) u_ctl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({tok_i, run_i}),
    .q    (ctl_s)
  );

  osc_sync2 #(.W(LEN_W)) u_len_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (len_i),
    .q    (len_s)
  );

  assign run_s   = ctl_s[0];
  assign restart = ctl_s[1] ^ tok_q;
  assign run_s_o = run_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= TMR_IDLE;
      cnt_o   <= '0;
      len_q_o <= '0;
      tok_q   <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      tok_q <= ctl_s[1];
      if (!run_s) begin
        state_o <= TMR_IDLE;
        cnt_o   <= '0;
        ready_o <= 1'b0;
      end else if (restart || state_o == TMR_IDLE) begin
        state_o <= TMR_WAIT;
        len_q_o <= len_s;
        cnt_o   <= len_s - LEN_W'(1);
        ready_o <= 1'b0;
      end else if (state_o == TMR_WAIT) begin
        if (cnt_o == '0) begin
          state_o <= TMR_READY;
          ready_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
  import osc_wait_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       sysclk_sel,
  input  logic       sleep_req,
  output logic       fen,
  output logic       sen,
  output logic [1:0] sel,
  output logic [7:0] rdata,
  output logic       ftok,
  output logic       stok
);
  logic fen_nx, sen_nx, sleep_q;
  logic fen_rise, sen_rise, wake;

  // the enable of the oscillator feeding the system clock cannot be cleared
  assign fen_nx = wdata[FEN_BIT] | (fen & (sysclk_sel == SRC_FAST));
  assign sen_nx = wdata[SEN_BIT] | (sen & (sysclk_sel == SRC_SLOW));

  assign fen_rise = wr_en & ~fen & fen_nx;
  assign sen_rise = wr_en & ~sen & sen_nx;
  assign wake     = sleep_q & ~sleep_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen     <= 1'b1;
      sen     <= 1'b1;
      sel     <= 2'd0;
      sleep_q <= 1'b0;
      ftok    <= 1'b0;
      stok    <= 1'b0;
    end else begin
      sleep_q <= sleep_req;
      if (wr_en) begin
        fen <= fen_nx;
        sen <= sen_nx;
        sel <= wdata[SEL_LSB +: 2];
      end
      if (fen_rise || wake) ftok <= ~ftok;
      if (sen_rise)         stok <= ~stok;
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[FEN_BIT]       = fen;
    rdata[SEN_BIT]       = sen;
    rdata[SEL_LSB +: 2]  = sel;
  end
endmodule

// File: rtl/osc_wait_ctrl.sv
module osc_wait_ctrl
  import osc_wait_pkg::*;
#(
  parameter int FAST_BASE = 128,
  parameter int SLOW_WAIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fclk,
  input  logic       sclk,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sleep_req,
  input  logic       sysclk_sel,
  output logic       fast_osc_on,
  output logic       slow_osc_on,
  output logic       fast_clk_ok,
  output logic       slow_clk_ok,
  output logic       cpu_hold
);
  localparam int FAST_MAX = FAST_BASE * 8;
  localparam int MAX_LEN  = (FAST_MAX > SLOW_WAIT) ? FAST_MAX : SLOW_WAIT;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic       fen, sen, ftok, stok;
  logic [1:0] sel;

  osc_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .sysclk_sel(sysclk_sel),
    .sleep_req (sleep_req),
    .fen       (fen),
    .sen       (sen),
    .sel       (sel),
    .rdata     (rdata),
    .ftok      (ftok),
    .stok      (stok)
  );

  assign fast_osc_on = fen & ~sleep_req;
  assign slow_osc_on = sen;

  logic [NUM_CH-1:0] ch_clk, ch_run, ch_tok, ch_rdy, ch_run_s, ch_rst_n;
  logic [CNT_W-1:0]  ch_len   [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt   [NUM_CH];
  logic [CNT_W-1:0]  ch_len_q [NUM_CH];
  tmr_state_e        ch_state [NUM_CH];

  assign ch_clk[CH_FAST] = fclk;
  assign ch_clk[CH_SLOW] = sclk;
  assign ch_run[CH_FAST] = fast_osc_on;
  assign ch_run[CH_SLOW] = slow_osc_on;
  assign ch_tok[CH_FAST] = ftok;
  assign ch_tok[CH_SLOW] = stok;
  assign ch_len[CH_FAST] = CNT_W'(fast_wait_len(sel, FAST_BASE));
  assign ch_len[CH_SLOW] = CNT_W'(SLOW_WAIT);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    osc_rst_sync u_rst (
      .clk    (ch_clk[g]),
      .arst_n (rst_n),
      .rst_n_o(ch_rst_n[g])
    );

    osc_wait_timer #(.LEN_W(CNT_W)) u_tmr (
      .clk    (ch_clk[g]),
      .rst_n  (ch_rst_n[g]),
      .run_i  (ch_run[g]),
      .tok_i  (ch_tok[g]),
      .len_i  (ch_len[g]),
      .ready_o(ch_rdy[g]),
      .state_o(ch_state[g]),
      .cnt_o  (ch_cnt[g]),
      .len_q_o(ch_len_q[g]),
      .run_s_o(ch_run_s[g])
    );
  end

  assign fast_clk_ok = ch_rdy[CH_FAST];
  assign slow_clk_ok = ch_rdy[CH_SLOW];

  // bring the fast ready back to the bus domain to release the CPU
  logic fast_ok_bus;
  osc_sync2 #(.W(1)) u_ok_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ch_rdy[CH_FAST]),
    .q    (fast_ok_bus)
  );

  logic hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_q <= 1'b1;
    else if (fast_ok_bus) hold_q <= 1'b0;
  end
  assign cpu_hold = hold_q;

  // named views for the bound checker
  tmr_state_e       f_state, s_state;
  logic [CNT_W-1:0] f_cnt, s_cnt, f_len_q, s_len_q;
  logic             f_run_s, s_run_s;
  assign f_state = ch_state[CH_FAST];
  assign s_state = ch_state[CH_SLOW];
  assign f_cnt   = ch_cnt[CH_FAST];
  assign s_cnt   = ch_cnt[CH_SLOW];
  assign f_len_q = ch_len_q[CH_FAST];
  assign s_len_q = ch_len_q[CH_SLOW];
  assign f_run_s = ch_run_s[CH_FAST];
  assign s_run_s = ch_run_s[CH_SLOW];
endmodule

// File: rtl/osc_wait_chk.sv
module osc_wait_chk
  import osc_wait_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fclk,
  input logic             sclk,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             sysclk_sel,
  input logic             cpu_hold,
  input logic             fast_ok_bus,
  input logic             fast_clk_ok,
  input logic             slow_clk_ok,
  input tmr_state_e       f_state,
  input tmr_state_e       s_state,
  input logic [CNT_W-1:0] f_cnt,
  input logic [CNT_W-1:0] s_cnt,
  input logic [CNT_W-1:0] f_len_q,
  input logic [CNT_W-1:0] s_len_q,
  input logic             f_run_s,
  input logic             s_run_s
);
  assert_fast_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[FEN_BIT] && sysclk_sel == SRC_FAST && rdata[FEN_BIT]) |=> rdata[FEN_BIT]);

  assert_slow_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[SEN_BIT] && sysclk_sel == SRC_SLOW && rdata[SEN_BIT]) |=> rdata[SEN_BIT]);

  assert_hold_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> $past(fast_ok_bus));

  assert_hold_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |=> !cpu_hold);

  assert_fast_cnt_bound_R10: assert property (@(posedge fclk) disable iff (!rst_n)
    (f_state == TMR_WAIT) |-> (f_cnt < f_len_q));

  assert_slow_cnt_bound_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    (s_state == TMR_WAIT) |-> (s_cnt < s_len_q));

  assert_fast_stop_R7: assert property (@(posedge fclk) disable iff (!rst_n)
    !f_run_s |=> !fast_clk_ok);

  assert_slow_stop_R7: assert property (@(posedge sclk) disable iff (!rst_n)
    !s_run_s |=> !slow_clk_ok);
endmodule

bind osc_wait_ctrl osc_wait_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fclk       (fclk),
  .sclk       (sclk),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .sysclk_sel (sysclk_sel),
  .cpu_hold   (cpu_hold),
  .fast_ok_bus(fast_ok_bus),
  .fast_clk_ok(fast_clk_ok),
  .slow_clk_ok(slow_clk_ok),
  .f_state    (f_state),
  .s_state    (s_state),
  .f_cnt      (f_cnt),
  .s_cnt      (s_cnt),
  .f_len_q    (f_len_q),
  .s_len_q    (s_len_q),
  .f_run_s    (f_run_s),
  .s_run_s    (s_run_s)
);

// File: tb/tb_osc_wait_ctrl.sv
`timescale 1ns/1ps
module tb_osc_wait_ctrl;
  logic clk = 0, fclk = 0, sclk = 0;
  logic rst_n, wr_en, sleep_req, sysclk_sel;
  logic [7:0] wdata, rdata;
  logic fast_osc_on, slow_osc_on, fast_clk_ok, slow_clk_ok, cpu_hold;

  always #2  clk  = ~clk;   // 250 MHz
  always #3  fclk = ~fclk;
  always #20 sclk = ~sclk;

  osc_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fclk(fclk), .sclk(sclk),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .sleep_req(sleep_req), .sysclk_sel(sysclk_sel),
    .fast_osc_on(fast_osc_on), .slow_osc_on(slow_osc_on),
    .fast_clk_ok(fast_clk_ok), .slow_clk_ok(slow_clk_ok),
    .cpu_hold(cpu_hold)
  );

  int n_chk = 0, n_err = 0;
  int fcyc = 0, scyc = 0;
  bit done = 0;
  always @(posedge fclk) fcyc++;
  always @(posedge sclk) scyc++;

  // {select code, expected fast wait length}
  localparam logic [12:0] VEC [0:3] = '{
    {2'd3, 11'd128}, {2'd2, 11'd256}, {2'd1, 11'd512}, {2'd0, 11'd1024}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fast(input int start, output int n);
    for (int k = 0; k < 3000 && !fast_clk_ok; k++) @(negedge fclk);
    n = fcyc - start;
  endtask

  task automatic wait_slow(input int start, output int n);
    for (int k = 0; k < 600 && !slow_clk_ok; k++) @(negedge sclk);
    n = scyc - start;
  endtask

  initial begin
    int t0, n;
    rst_n = 0; wr_en = 0; wdata = '0; sleep_req = 0; sysclk_sel = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 reset register value", rdata, 8'h03);
    chk("R3 cpu_hold in reset", cpu_hold, 1);
    chk("R2 oscillators on in reset", {slow_osc_on, fast_osc_on}, 2'b11);
    rst_n = 1; t0 = fcyc;
    wait_fast(t0, n);
    chk_rng("R2 first fast wait", n, 1024, 1032);
    repeat (6) @(negedge clk);
    chk("R3 cpu_hold released", cpu_hold, 0);

    // vector walk: each select code, fast oscillator not the system clock
    sysclk_sel = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] code;
      int len;
      code = VEC[i][12:11];
      len  = int'(VEC[i][10:0]);
      reg_write({2'b00, code, 2'b00, 2'b10});
      chk("R4 read after fast disable", rdata, {2'b00, code, 4'b0010});
      chk("R7 fast_osc_on after disable", fast_osc_on, 0);
      repeat (8) @(negedge fclk);
      chk("R7 fast ok drops on disable", fast_clk_ok, 0);
      reg_write({2'b00, code, 2'b00, 2'b11});
      t0 = fcyc;
      wait_fast(t0, n);
      chk_rng("R1 R5 fast wait for code", n, len, len + 6);
    end

    // reserved bits
    reg_write(8'hFF);
    chk("R4 reserved bits read zero", rdata, 8'h33);

    // fast is the system clock: disable ignored
    sysclk_sel = 1'b0;
    reg_write(8'h32);
    chk("R6 fast enable kept", rdata[0], 1);
    repeat (8) @(negedge fclk);
    chk("R6 fast ok kept", fast_clk_ok, 1);

    // slow disable allowed, then slow restart
    reg_write(8'h31);
    chk("R7 slow enable cleared", rdata[1], 0);
    repeat (8) @(negedge sclk);
    chk("R7 slow ok drops", slow_clk_ok, 0);
    reg_write(8'h33);
    t0 = scyc;
    wait_slow(t0, n);
    chk_rng("R8 slow wait", n, 256, 262);

    // slow is the system clock: disable ignored
    sysclk_sel = 1'b1;
    reg_write(8'h31);
    chk("R6 slow enable kept", rdata[1], 1);
    repeat (6) @(negedge sclk);
    chk("R6 slow ok kept", slow_clk_ok, 1);

    // sleep stops the fast oscillator, wake restarts the wait (code 3)
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk);
    chk("R9 fast_osc_on in sleep", fast_osc_on, 0);
    repeat (8) @(negedge fclk);
    chk("R9 fast ok in sleep", fast_clk_ok, 0);
    chk("R3 cpu_hold stays low in sleep", cpu_hold, 0);
    @(negedge clk); sleep_req = 1'b0;
    t0 = fcyc;
    wait_fast(t0, n);
    chk_rng("R5 wait after sleep exit", n, 128, 134);
    chk("R3 cpu_hold after wake", cpu_hold, 0);

    // select change mid-wait does not alter the running wait
    reg_write(8'h32);
    repeat (8) @(negedge fclk);
    reg_write(8'h33);
    t0 = fcyc;
    repeat (20) @(negedge fclk);
    reg_write(8'h03);
    wait_fast(t0, n);
    chk_rng("R10 running wait keeps length", n, 128, 134);
    chk("R10 new code stored", rdata, 8'h03);
    reg_write(8'h02);
    repeat (8) @(negedge fclk);
    reg_write(8'h03);
    t0 = fcyc;
    wait_fast(t0, n);
    chk_rng("R10 next wait uses new code", n, 1024, 1030);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule